// File: doc/BRIEF.md
# Significand Product Stage with Sticky Fold

This block is the multiply front end of a fused multiply-add datapath for single-precision operands. It takes two normalised 24-bit significands, each with its leading one present, and their unbiased exponents and signs. It returns a 27-bit product significand, an exponent and a sign. The 27 bits are the 24 kept product bits, a guard bit, a round bit and a sticky bit, so a later adder and rounder can use the result as it is.

Each significand is left-justified in a 32-bit word. The double-width product is built from four 16x16 partial products. Only the upper 32 bits are kept, and every bit below them is collapsed into the least significant position. A final alignment step takes either a 5-bit or a 4-bit sticky shift. The choice depends on whether the product reached 2.0, and in that case the exponent goes up by one. A negate control flips the product sign, which serves the multiply-subtract variant. Results are registered once, with a valid flag beside them.

Top module: `sm_sig_product`

## Requirements
- R1: `out_valid` is 0 after reset and, in each cycle, equals the value `in_valid` had at the previous rising clock edge.
- R2: When the exact 48-bit product P = x_sig*y_sig has bit 47 clear, `out_sig[26:1]` equals P[46:21].
- R3: When P bit 47 is set, `out_sig[26:1]` equals P[47:22] and the exponent carries an extra +1.
- R4: `out_sig[0]` is the OR of every product bit below the kept 26 bits: P[20:0] when P[47] is clear, and P[21:0] when it is set.
- R5: `out_sig[26]` is 1 for every valid result.
- R6: `out_exp` is the two's-complement sum x_exp + y_exp, plus 1 when P[47] is set. Inputs are 10-bit signed and the output is 12-bit signed.
- R7: `out_sign` equals x_sign XOR y_sign XOR negate.
- R8: While `in_valid` is 0, `out_sig`, `out_exp` and `out_sign` keep their last values, whatever the operand inputs do.
- R9: After reset, `out_sig`, `out_exp` and `out_sign` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| x_sig | input | 24 | First significand, bit 23 set |
| x_exp | input | 10 | First unbiased exponent, signed |
| x_sign | input | 1 | First operand sign |
| y_sig | input | 24 | Second significand, bit 23 set |
| y_exp | input | 10 | Second unbiased exponent, signed |
| y_sign | input | 1 | Second operand sign |
| negate | input | 1 | Invert the product sign |
| out_valid | output | 1 | Result registers hold a new product |
| out_sig | output | 27 | Product significand with guard, round and sticky |
| out_exp | output | 12 | Product exponent, signed |
| out_sign | output | 1 | Product sign |

## Verification
Every result (significand, sticky, exponent, sign and valid) is due exactly one clock edge after the operands are presented. The bench drives operands on a falling edge and compares all outputs on the next falling edge. At that point the single register stage has captured them, and the next vector is presented in the same step, so back-to-back issue is covered. For the hold check, `in_valid` is dropped while the operands are changed. The outputs are then sampled on three successive falling edges against the last captured product.

// File: rtl/sm_pkg.sv
package sm_pkg;
    localparam int SIG_W     = 24;
    localparam int WORD_W    = 32;
    localparam int HALF_W    = WORD_W / 2;
    localparam int EXP_W     = 10;
    localparam int OUT_EXP_W = EXP_W + 2;
    localparam int EXT_W     = 3;
    localparam int RES_W     = SIG_W + EXT_W;
    localparam int JUST_SH   = WORD_W - SIG_W;

    typedef struct packed {
        logic                        vld;
        logic [RES_W-1:0]            sig;
        logic signed [OUT_EXP_W-1:0] exp;
        logic                        sign;
    } sm_state_t;
endpackage

// File: rtl/sm_half_mul.sv
module sm_half_mul #(
    parameter int HW = 16
) (
    input  logic [HW-1:0]   a,
    input  logic [HW-1:0]   b,
    output logic [2*HW-1:0] p
);
    assign p = {{HW{1'b0}}, a} * {{HW{1'b0}}, b};
endmodule

// File: rtl/sm_pp_combine.sv
module sm_pp_combine #(
    parameter int WW = 32
) (
    input  logic [WW-1:0] pp_ll,
    input  logic [WW-1:0] pp_lh,
    input  logic [WW-1:0] pp_hl,
    input  logic [WW-1:0] pp_hh,
    output logic [WW-1:0] upper_st
);
    localparam int HW = WW / 2;
    logic [2*WW-1:0] full;

    always_comb begin
        full = {pp_hh, {WW{1'b0}}}
             + {{HW{1'b0}}, pp_lh, {HW{1'b0}}}
             + {{HW{1'b0}}, pp_hl, {HW{1'b0}}}
             + {{WW{1'b0}}, pp_ll};
        upper_st    = full[2*WW-1:WW];
        upper_st[0] = full[WW] | (|full[WW-1:0]);
    end
endmodule

// File: rtl/sm_sticky_align.sv
module sm_sticky_align #(
    parameter int WW    = 32,
    parameter int RES_W = 27
) (
    input  logic [WW-1:0]    word,
    output logic [RES_W-1:0] sig,
    output logic             carry
);
    localparam int KEEP = RES_W - 1;

    always_comb begin
        carry = word[WW-1];
        if (carry) begin
            sig = {word[WW-1 -: KEEP], |word[WW-KEEP-1:0]};
        end else begin
            sig = {word[WW-2 -: KEEP], |word[WW-KEEP-2:0]};
        end
    end
endmodule

// File: rtl/sm_sig_product.sv
module sm_sig_product
    import sm_pkg::*;
#(
    parameter int P_SIG_W = SIG_W,
    parameter int P_EXP_W = EXP_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [P_SIG_W-1:0]          x_sig,
    input  logic signed [P_EXP_W-1:0]   x_exp,
    input  logic                        x_sign,
    input  logic [P_SIG_W-1:0]          y_sig,
    input  logic signed [P_EXP_W-1:0]   y_exp,
    input  logic                        y_sign,
    input  logic                        negate,
    output logic                        out_valid,
    output logic [RES_W-1:0]            out_sig,
    output logic signed [OUT_EXP_W-1:0] out_exp,
    output logic                        out_sign
);
    localparam int SH = WORD_W - P_SIG_W;

    logic [WORD_W-1:0] xw, yw;
    logic [HALF_W-1:0] xh [2];
    logic [HALF_W-1:0] yh [2];
    logic [WORD_W-1:0] pp [4];
    logic [WORD_W-1:0] upper_st;
    logic [RES_W-1:0]  al_sig;
    logic              al_carry;
    logic signed [OUT_EXP_W-1:0] ex, ey;

    assign xw = {x_sig, {SH{1'b0}}};
    assign yw = {y_sig, {SH{1'b0}}};

    generate
        for (genvar h = 0; h < 2; h++) begin : g_split
            assign xh[h] = xw[h*HALF_W +: HALF_W];
            assign yh[h] = yw[h*HALF_W +: HALF_W];
        end
        for (genvar i = 0; i < 4; i++) begin : g_pp
            sm_half_mul #(.HW(HALF_W)) u_mul (
                .a (xh[i/2]),
                .b (yh[i%2]),
                .p (pp[i])
            );
        end
    endgenerate

    sm_pp_combine #(.WW(WORD_W)) u_comb (
        .pp_ll    (pp[0]),
        .pp_lh    (pp[1]),
        .pp_hl    (pp[2]),
        .pp_hh    (pp[3]),
        .upper_st (upper_st)
    );

    sm_sticky_align #(.WW(WORD_W), .RES_W(RES_W)) u_align (
        .word  (upper_st),
        .sig   (al_sig),
        .carry (al_carry)
    );

    assign ex = OUT_EXP_W'(x_exp);
    assign ey = OUT_EXP_W'(y_exp);

    sm_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.sig  = al_sig;
            st_d.exp  = ex + ey + {{(OUT_EXP_W-1){1'b0}}, al_carry};
            st_d.sign = x_sign ^ y_sign ^ negate;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_sig   = st_q.sig;
    assign out_exp   = st_q.exp;
    assign out_sign  = st_q.sign;

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hidden_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_sig[RES_W-1]);
    assert_exp_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_exp == $past(ex) + $past(ey)) ||
                     (out_exp == $past(ex) + $past(ey) + 1));
    assert_sign_rule_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_sign == ($past(x_sign) ^ $past(y_sign) ^ $past(negate)));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sig) && $stable(out_exp) && $stable(out_sign));
    assert_norm_inputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> x_sig[P_SIG_W-1] && y_sig[P_SIG_W-1]);
endmodule

// File: tb/tb_sm_sig_product.sv
module tb_sm_sig_product;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [23:0] x_sig = 24'h800000, y_sig = 24'h800000;
    logic signed [9:0] x_exp = '0, y_exp = '0;
    logic x_sign = 1'b0, y_sign = 1'b0, negate = 1'b0;
    logic out_valid;
    logic [26:0] out_sig;
    logic signed [11:0] out_exp;
    logic out_sign;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] lfsr = 32'hACE1_2357;

    always #2 clk = ~clk;

    sm_sig_product dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .x_sig(x_sig), .x_exp(x_exp), .x_sign(x_sign),
        .y_sig(y_sig), .y_exp(y_exp), .y_sign(y_sign),
        .negate(negate), .out_valid(out_valid), .out_sig(out_sig),
        .out_exp(out_exp), .out_sign(out_sign)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    // Presents one operand pair at a falling edge, checks at the next falling edge.
    task automatic run_vec(input logic [23:0] a, input logic [23:0] b,
                           input logic signed [9:0] ea, input logic signed [9:0] eb,
                           input logic sa, input logic sb, input logic ng);
        logic [47:0] p;
        logic [26:0] exp_sig;
        logic signed [11:0] exp_e;
        logic ovf;
        in_valid = 1'b1;
        x_sig = a; y_sig = b; x_exp = ea; y_exp = eb;
        x_sign = sa; y_sign = sb; negate = ng;
        p   = {24'h0, a} * {24'h0, b};
        ovf = p[47];
        exp_sig = ovf ? {p[47:22], |p[21:0]} : {p[46:21], |p[20:0]};
        exp_e   = 12'(ea) + 12'(eb) + (ovf ? 12'sd1 : 12'sd0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R1 valid", 64'(out_valid), 64'd1);
        if (ovf) chk(out_sig[26:1] == exp_sig[26:1], "R3 sig", 64'(out_sig), 64'(exp_sig));
        else     chk(out_sig[26:1] == exp_sig[26:1], "R2 sig", 64'(out_sig), 64'(exp_sig));
        chk(out_sig[0] == exp_sig[0], "R4 sticky", 64'(out_sig[0]), 64'(exp_sig[0]));
        chk(out_sig[26] == 1'b1, "R5 hidden", 64'(out_sig[26]), 64'd1);
        chk(out_exp == exp_e, "R6 exp", 64'(out_exp), 64'(exp_e));
        chk(out_sign == (sa ^ sb ^ ng), "R7 sign", 64'(out_sign), 64'(sa ^ sb ^ ng));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [26:0] held_sig;
        logic signed [11:0] held_exp;
        logic held_sign;
        repeat (3) @(negedge clk);
        // R9 / R1: reset state
        chk(out_valid == 1'b0, "R1 reset valid", 64'(out_valid), 64'd0);
        chk(out_sig == '0, "R9 reset sig", 64'(out_sig), 64'd0);
        chk(out_exp == '0, "R9 reset exp", 64'(out_exp), 64'd0);
        chk(out_sign == 1'b0, "R9 reset sign", 64'(out_sign), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 idle valid", 64'(out_valid), 64'd0);

        // Corners: minimum, maximum, exactly-two boundary neighbours, exponent extremes.
        run_vec(24'h800000, 24'h800000, 10'sd0, 10'sd0, 1'b0, 1'b0, 1'b0);
        run_vec(24'hFFFFFF, 24'hFFFFFF, 10'sd511, 10'sd511, 1'b1, 1'b0, 1'b0);
        run_vec(24'h800001, 24'hFFFFFF, -10'sd512, -10'sd512, 1'b1, 1'b1, 1'b1);
        run_vec(24'hC00000, 24'hAAAAAA, -10'sd126, 10'sd127, 1'b0, 1'b1, 1'b1);
        run_vec(24'hB504F3, 24'hB504F3, 10'sd3, -10'sd7, 1'b0, 1'b0, 1'b1);
        run_vec(24'hB504F4, 24'hB504F4, 10'sd1, 10'sd1, 1'b1, 1'b1, 1'b0);
        run_vec(24'hC00000, 24'hC00000, 10'sd0, -10'sd1, 1'b0, 1'b0, 1'b0);

        // Walking-one sweep over both significands.
        for (int i = 0; i < 23; i++) begin
            for (int j = 0; j < 23; j++) begin
                run_vec(24'h800000 | (24'h1 << i), 24'h800000 | (24'h1 << j),
                        10'(i * 17 - 200), 10'(j * 13 - 150),
                        i[0], j[0], i[1] ^ j[2]);
            end
        end

        // Pseudo-random sweep.
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r1, r2;
            lfsr = step(lfsr); r1 = lfsr;
            lfsr = step(lfsr); r2 = lfsr;
            run_vec({1'b1, r1[22:0]}, {1'b1, r2[22:0]},
                    10'(r1[31:23]) - 10'sd256, 10'(r2[31:22]),
                    r1[31], r2[31], r1[0] ^ r2[0]);
        end

        // R8: drop valid and disturb operands; outputs must not move.
        run_vec(24'hFFFFFF, 24'h800001, 10'sd5, 10'sd6, 1'b1, 1'b0, 1'b0);
        held_sig = out_sig; held_exp = out_exp; held_sign = out_sign;
        in_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            x_sig = 24'h900000 + 24'(k); y_sig = 24'hE00000; x_exp = 10'sd100;
            y_exp = -10'sd3; x_sign = 1'b0; negate = 1'b1;
            @(negedge clk);
            chk(out_valid == 1'b0, "R1 drop valid", 64'(out_valid), 64'd0);
            chk(out_sig == held_sig, "R8 hold sig", 64'(out_sig), 64'(held_sig));
            chk(out_exp == held_exp, "R8 hold exp", 64'(out_exp), 64'(held_exp));
            chk(out_sign == held_sign, "R8 hold sign", 64'(out_sign), 64'(held_sign));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule